// File: doc/BRIEF.md
# Soft-Start Ramp and Power-Good Sequencer

This block controls the start-up of a step-down converter. When the converter is enabled, it raises a digital reference code from zero to full scale over a soft-start time given in clock cycles. The code feeds the reference DAC of the feedback comparator. A flag rises when the ramp reaches full scale.

The block also drives the power-good line. Two digitised comparator flags report the output voltage. One says the output is at or above 90 % of its setpoint. The other says the output has dropped more than 15 % below its setpoint. Power-good stays low until soft-start has finished. It then switches between these two thresholds with hysteresis. A change in either direction takes effect only after its condition has held without a break for a deglitch time. Clearing the enable, or raising the fault-shutdown input, returns the whole sequence to its idle state.

Top module: `softstart_pg_seq`

## Requirements
- R1: While reset is applied, and while the converter is disabled, `ref_code` is 0, `ss_done` is 0 and `pg_release` is 0. `pg_release` = 1 means the open-drain line is released (power good). 0 means the line is pulled low.
- R2: While `en`=1 and `fault`=0, `ref_code` rises by exactly one every STEP cycles. STEP = SS_CYCLES / (2^REF_W − 1), rounded down, with a minimum of 1. The first increment happens on the STEP-th clock edge that samples the block active.
- R3: `ref_code` stops at full scale (all ones) and holds there. `ss_done` rises on the same edge on which the code reaches full scale.
- R4: On the first edge that samples `en`=0 or `fault`=1, `ref_code`, `ss_done` and `pg_release` all go to 0. When the block becomes active again, the ramp restarts from zero.
- R5: `pg_release` is never 1 while `ss_done` is 0.
- R6: When power-good is low, it rises on the DGL_CYCLES-th consecutive edge that samples both `ss_done`=1 and `vo_above_good`=1.
- R7: When power-good is high, it falls on the DGL_CYCLES-th consecutive edge that samples `vo_below_drop`=1.
- R8: If a qualifying condition holds for fewer than DGL_CYCLES consecutive edges, power-good does not change. Any break in the condition restarts the count from zero.
- R9: Power-good keeps its state while both comparator flags are 0. `vo_below_drop` has no effect while power-good is low, and `vo_above_good` has no effect while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Converter enable |
| fault | input | 1 | Fault shutdown request; 1 forces idle |
| vo_above_good | input | 1 | Output at or above 90 % of setpoint |
| vo_below_drop | input | 1 | Output more than 15 % below setpoint |
| ref_code | output | REF_W | Soft-start reference code for the DAC |
| ss_done | output | 1 | Soft-start complete (code at full scale) |
| pg_release | output | 1 | 1 releases the power-good line, 0 pulls it low |

## Verification
The hardest situation to reach is the exact edge of the deglitch window in both directions. A run of DGL_CYCLES−1 qualifying edges must leave power-good unchanged, and a run of DGL_CYCLES edges must flip it. Power-good can only leave its low state after a full soft-start ramp. The bench therefore uses a small configuration (4-bit code, 3-cycle step, 5-cycle deglitch) so each ramp takes only 45 cycles. It drives pulses of every length from 1 to DGL_CYCLES on the drop flag and then on the good flag, each time from the state where that flag matters. Fault and disable are applied mid-sequence, and the restarted ramp is checked cycle by cycle against the arithmetic STEP schedule.

// File: rtl/stsq_pkg.sv
package stsq_pkg;

  typedef enum logic {
    PG_LOW  = 1'b0,
    PG_HIGH = 1'b1
  } pg_state_e;

  // cycles per reference step: span divided by the number of steps, at least 1
  function automatic int unsigned ramp_step(input int unsigned ss_cycles,
                                            input int unsigned ref_w);
    int unsigned full;
    int unsigned q;
    full = (32'd1 << ref_w) - 32'd1;
    q    = ss_cycles / full;
    return (q < 32'd1) ? 32'd1 : q;
  endfunction

endpackage

// File: rtl/stsq_rst_sync.sv
module stsq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/stsq_ramp.sv
module stsq_ramp #(
  parameter int unsigned REF_W    = 10,
  parameter int unsigned STEP_CYC = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  output logic [REF_W-1:0] code_o,
  output logic             done_o
);

  localparam logic [REF_W-1:0] FULL = '1;
  localparam int unsigned      PS_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [REF_W-1:0] code_q, code_d;
  logic             done_q, done_d;
  logic             tick;
  logic             at_full;

  assign at_full = (code_q == FULL);

  // step prescaler: absent when every cycle is a step
  generate
    if (STEP_CYC <= 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      logic [PS_W-1:0] ps_q, ps_d;
      always_comb begin
        ps_d = ps_q;
        if (!active_i || at_full)               ps_d = '0;
        else if (ps_q == PS_W'(STEP_CYC - 1))   ps_d = '0;
        else                                    ps_d = ps_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
      end
      assign tick = (ps_q == PS_W'(STEP_CYC - 1));
    end
  endgenerate

  always_comb begin
    code_d = code_q;
    if (!active_i)             code_d = '0;
    else if (!at_full && tick) code_d = code_q + 1'b1;
    done_d = active_i && (code_d == FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      code_q <= code_d;
      done_q <= done_d;
    end
  end

  assign code_o = code_q;
  assign done_o = done_q;

  assert_ramp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> (code_q == $past(code_q) || code_q == $past(code_q) + REF_W'(1)));

  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (code_q == '0 && !done_q));

  assert_done_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> code_q == FULL);

endmodule

// File: rtl/stsq_pg_filter.sv
module stsq_pg_filter
  import stsq_pkg::*;
#(
  parameter int unsigned DGL_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic ss_done_i,
  input  logic above_i,
  input  logic below_i,
  output logic pg_o
);

  localparam int unsigned CW = (DGL_CYCLES > 1) ? $clog2(DGL_CYCLES) : 1;

  pg_state_e state_q, state_d;
  logic      cond;
  logic      flip_w;

  // the flag that matters depends on the present state (hysteresis)
  assign cond = (state_q == PG_HIGH) ? below_i : (ss_done_i & above_i);

  generate
    if (DGL_CYCLES <= 1) begin : g_no_dgl
      assign flip_w = active_i & cond;
    end else begin : g_dgl
      logic [CW-1:0] cnt_q, cnt_d;
      always_comb begin
        cnt_d  = cnt_q;
        flip_w = 1'b0;
        if (!active_i || !cond) begin
          cnt_d = '0;
        end else if (cnt_q == CW'(DGL_CYCLES - 1)) begin
          cnt_d  = '0;
          flip_w = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (!active_i)   state_d = PG_LOW;
    else if (flip_w) state_d = (state_q == PG_HIGH) ? PG_LOW : PG_HIGH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PG_LOW;
    else        state_q <= state_d;
  end

  assign pg_o = (state_q == PG_HIGH);

  assert_pg_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done_i |=> !pg_o);

  assert_pg_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_o) |-> ($past(above_i) && $past(ss_done_i)));

  assert_pg_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_o) |-> ($past(below_i) || !$past(active_i)));

endmodule

// File: rtl/softstart_pg_seq.sv
module softstart_pg_seq
  import stsq_pkg::*;
#(
  parameter int unsigned REF_W      = 10,
  parameter int unsigned SS_CYCLES  = 30000,
  parameter int unsigned DGL_CYCLES = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fault,
  input  logic             vo_above_good,
  input  logic             vo_below_drop,
  output logic [REF_W-1:0] ref_code,
  output logic             ss_done,
  output logic             pg_release
);

  localparam int unsigned STEP_CYC = ramp_step(SS_CYCLES, REF_W);

  logic rst_n_s;
  logic active;
  logic done_w;

  assign active = en & ~fault;

  stsq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  stsq_ramp #(
    .REF_W    (REF_W),
    .STEP_CYC (STEP_CYC)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .active_i (active),
    .code_o   (ref_code),
    .done_o   (done_w)
  );

  stsq_pg_filter #(
    .DGL_CYCLES (DGL_CYCLES)
  ) u_pg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .active_i  (active),
    .ss_done_i (done_w),
    .above_i   (vo_above_good),
    .below_i   (vo_below_drop),
    .pg_o      (pg_release)
  );

  assign ss_done = done_w;

endmodule

// File: tb/sim_softstart_pg_seq.sv
module sim_softstart_pg_seq;

  localparam int REF_W = 4;
  localparam int SS    = 45;
  localparam int DGL   = 5;
  localparam int FULL  = (1 << REF_W) - 1;
  localparam int STEP  = (SS / FULL < 1) ? 1 : SS / FULL;
  localparam int DONE_K = STEP * FULL;

  logic clk = 1'b0;
  logic rst_n, en, fault, above, below;
  logic [REF_W-1:0] ref_code;
  logic ss_done, pg_release;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  softstart_pg_seq #(.REF_W(REF_W), .SS_CYCLES(SS), .DGL_CYCLES(DGL)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .fault(fault),
    .vo_above_good(above), .vo_below_drop(below),
    .ref_code(ref_code), .ss_done(ss_done), .pg_release(pg_release)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_code(input int k);
    return (k / STEP > FULL) ? FULL : k / STEP;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; fault = 1'b0; above = 1'b0; below = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 code in reset", int'(ref_code), 0);
    chk("R1 done in reset", int'(ss_done), 0);
    chk("R1 pg in reset", int'(pg_release), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle code", int'(ref_code), 0);
    chk("R1 idle pg", int'(pg_release), 0);

    // first ramp with the good flag already high: R2 R3 R5 R6
    above = 1'b1; en = 1'b1;
    for (int k = 1; k <= DONE_K + DGL + 8; k++) begin
      @(negedge clk);
      chk("R2 ramp code", int'(ref_code), exp_code(k));
      chk("R3 done flag", int'(ss_done), (k >= DONE_K) ? 1 : 0);
      chk("R5 R6 pg during and after ramp", int'(pg_release), (k >= DONE_K + DGL) ? 1 : 0);
    end

    // short drop pulses must not clear power-good: R8 (good flag ignored while high: R9)
    for (int len = 1; len < DGL; len++) begin
      above = 1'b0; below = 1'b1;
      repeat (len) @(negedge clk);
      below = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 short drop ignored", int'(pg_release), 1);
    end
    below = 1'b1;
    repeat (DGL - 1) @(negedge clk);
    chk("R7 not yet fallen", int'(pg_release), 1);
    @(negedge clk);
    chk("R7 fell after full window", int'(pg_release), 0);
    below = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 hold low between thresholds", int'(pg_release), 0);
    below = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 drop flag ignored while low", int'(pg_release), 0);
    below = 1'b0;

    // short good pulses must not raise power-good: R8
    for (int len = 1; len < DGL; len++) begin
      above = 1'b1;
      repeat (len) @(negedge clk);
      above = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 short good ignored", int'(pg_release), 0);
    end
    // broken run: DGL-1, gap, DGL-1
    above = 1'b1; repeat (DGL - 1) @(negedge clk);
    above = 1'b0; @(negedge clk);
    above = 1'b1; repeat (DGL - 1) @(negedge clk);
    chk("R8 interrupted run restarts", int'(pg_release), 0);
    above = 1'b0; @(negedge clk);
    above = 1'b1;
    repeat (DGL - 1) @(negedge clk);
    chk("R6 not yet risen", int'(pg_release), 0);
    @(negedge clk);
    chk("R6 rose after full window", int'(pg_release), 1);
    above = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 hold high between thresholds", int'(pg_release), 1);

    // fault shutdown: R4
    fault = 1'b1;
    @(negedge clk);
    chk("R4 fault clears code", int'(ref_code), 0);
    chk("R4 fault clears done", int'(ss_done), 0);
    chk("R4 fault clears pg", int'(pg_release), 0);
    repeat (5) @(negedge clk);
    chk("R4 code held at zero in fault", int'(ref_code), 0);
    fault = 1'b0;
    for (int k = 1; k <= DONE_K + 10; k++) begin
      @(negedge clk);
      chk("R4 R2 restarted ramp", int'(ref_code), exp_code(k));
      chk("R5 pg low without good flag", int'(pg_release), 0);
    end
    above = 1'b1;
    repeat (DGL - 1) @(negedge clk);
    chk("R6 waits window after ramp", int'(pg_release), 0);
    @(negedge clk);
    chk("R6 rises after window", int'(pg_release), 1);

    // disable mid-way: R4
    en = 1'b0;
    @(negedge clk);
    chk("R4 disable clears code", int'(ref_code), 0);
    chk("R4 disable clears pg", int'(pg_release), 0);
    en = 1'b1;
    for (int k = 1; k <= 2 * STEP; k++) begin
      @(negedge clk);
      chk("R4 re-enable ramp from zero", int'(ref_code), exp_code(k));
      chk("R5 pg low in new ramp", int'(pg_release), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule